// File: doc/BRIEF.md
# Three-Wire Codec Control Serializer

This block is a bus master for a three-wire control link used to program audio codec settings. The link carries a mode line, a shift clock and a data line. A host hands the block one byte plus a phase select through a valid/ready handshake. The phase select tags the byte as either an address byte or a data byte.

For each accepted request the block does four things in order:
- It drives the mode line to the level that matches the phase.
- It waits out a minimum setup interval.
- It shifts the eight bits out, least significant bit first. Each bit is placed on the data line while the shift clock is low, and the following rising clock edge latches it at the codec.
- It restores the idle line levels and reports completion.

All timing is counted in system clock cycles. The setup interval is derived from the system clock period, so it always covers at least 190 ns. Each half-period of the shift clock is a parameter.

Top module: `ctl3w_serializer`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the lines sit at their idle levels: `ln_clk` = 1, `ln_mode` = 1, `ln_data` = 0.
- R2: Each transfer shifts exactly 8 bits, least significant bit first. A receiver that samples `ln_data` on each rising edge of `ln_clk` rebuilds the accepted byte.
- R3: The mode line encodes the phase: `req_phase` = 0 (address) drives `ln_mode` low and `req_phase` = 1 (data) drives it high. That level is held for the whole transfer. While the setup interval runs, `ln_clk` stays 1 and `ln_data` stays 0.
- R4: The first falling edge of `ln_clk` comes at least ceil(190 ns / clock period) cycles after `ln_mode` takes its transfer level. At the default 10 ns period this is 19 cycles.
- R5: Each low half and each high half of `ln_clk` lasts `HALF_CYC` cycles (4 by default). `ln_data` changes only together with a falling clock edge and stays stable while the clock is high.
- R6: `req_ready` drops in the cycle after a request is accepted and stays low until the idle levels are back. A request held valid while the block is busy is accepted later, not dropped.
- R7: The byte and the phase are captured at acceptance. Changing `req_byte` or `req_phase` during a transfer has no effect on that transfer.
- R8: `done` is high for exactly one cycle. That cycle is the first one in which the idle levels are restored, and `req_ready` is high in it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_phase | input | 1 | 0 = address byte, 1 = data byte |
| req_byte | input | 8 | Byte to send |
| done | output | 1 | One-cycle pulse when the lines return to idle |
| ln_mode | output | 1 | Mode line to the codec |
| ln_clk | output | 1 | Shift clock to the codec |
| ln_data | output | 1 | Serial data to the codec |

## Verification
The bench rebuilds each byte from the data line at rising clock edges. A design that shifted MSB-first, or sent seven or nine bits, would produce a different byte or bit count.

It measures three intervals against the requirements:
- the setup run before the first falling edge, which a design that ignored the setup wait would make only a half-period long;
- every clock half-period, where an off-by-one timer reload shows up as 3 or 5 cycles;
- the mode level at each latch, which catches a design that inverts or fails to hold the phase.

It also covers three handshake cases:
- Back-to-back requests are held while the block is busy, and losing one leaves an expected item in the scoreboard.
- Inputs are scribbled during a transfer; a design that did not capture them sends the scribbled value.
- The done pulse is checked against the idle levels and against a second high cycle.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH
    } ctl_state_e;

    typedef struct packed {
        logic              tag;
        logic [WORD_W-1:0] payload;
    } xfer_req_t;

    typedef struct packed {
        logic mode;
        logic sclk;
        logic sdat;
    } line_lvl_t;

    localparam line_lvl_t LINES_IDLE = '{mode: 1'b1, sclk: 1'b1, sdat: 1'b0};

    // Whole cycles that cover a time given in ns, at least one.
    function automatic int cycles_covering(input int t_ns, input int period_ps);
        int c;
        c = (t_ns * 1000 + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ctl3w_timer.sv
module ctl3w_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         bit_o,
    output logic         last_o
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sh_q;
    logic [BW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            idx_q <= '0;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o  = sh_q[0];
    assign last_o = (idx_q == BW'(W - 1));
endmodule

// File: rtl/ctl3w_serializer.sv
module ctl3w_serializer
    import ctl3w_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int SETUP_NS      = 190,
    parameter int HALF_CYC      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_phase,
    input  logic [WORD_W-1:0] req_byte,
    output logic              done,
    output logic              ln_mode,
    output logic              ln_clk,
    output logic              ln_data
);
    localparam int SETUP_CYC = cycles_covering(SETUP_NS, CLK_PERIOD_PS);
    localparam int MAX_CYC   = max2(SETUP_CYC, HALF_CYC);
    localparam int CW        = max2(1, $clog2(MAX_CYC + 1));
    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HALF_LD  = CW'(HALF_CYC - 1);

    ctl_state_e    st_q, st_d;
    xfer_req_t     cap_q;
    line_lvl_t     lines;
    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;
    logic          accept, sh_shift, sh_bit, sh_last, fin, done_q;

    assign accept = req_valid && (st_q == ST_IDLE);

    ctl3w_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero_o   (tmr_zero)
    );

    ctl3w_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (req_byte),
        .shift    (sh_shift),
        .bit_o    (sh_bit),
        .last_o   (sh_last)
    );

    // Next-state and timer control.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = HALF_LD;
        sh_shift = 1'b0;
        fin      = 1'b0;
        unique case (st_q)
            ST_IDLE: if (accept) begin
                st_d     = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = SETUP_LD;
            end
            ST_SETUP: if (tmr_zero) begin
                st_d     = ST_LOW;
                tmr_load = 1'b1;
            end
            ST_LOW: if (tmr_zero) begin
                st_d     = ST_HIGH;
                tmr_load = 1'b1;
            end
            ST_HIGH: if (tmr_zero) begin
                if (sh_last) begin
                    st_d = ST_IDLE;
                    fin  = 1'b1;
                end else begin
                    st_d     = ST_LOW;
                    tmr_load = 1'b1;
                    sh_shift = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cap_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= fin;
            if (accept)
                cap_q <= '{tag: req_phase, payload: req_byte};
        end
    end

    // Line levels follow the registered state.
    always_comb begin
        unique case (st_q)
            ST_SETUP: lines = '{mode: cap_q.tag, sclk: 1'b1, sdat: 1'b0};
            ST_LOW:   lines = '{mode: cap_q.tag, sclk: 1'b0, sdat: sh_bit};
            ST_HIGH:  lines = '{mode: cap_q.tag, sclk: 1'b1, sdat: sh_bit};
            default:  lines = LINES_IDLE;
        endcase
    end

    assign ln_mode   = lines.mode;
    assign ln_clk    = lines.sclk;
    assign ln_data   = lines.sdat;
    assign req_ready = (st_q == ST_IDLE);
    assign done      = done_q;
endmodule

// File: rtl/ctl3w_checker.sv
module ctl3w_checker #(
    parameter int SETUP_CYC = 19,
    parameter int HALF_CYC  = 4
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic ln_mode,
    input logic ln_clk,
    input logic ln_data
);
    logic [15:0] setup_cnt, low_run;
    logic        seen_fall;

    always_ff @(posedge clk) begin
        if (rst || req_ready) begin
            setup_cnt <= '0;
            seen_fall <= 1'b0;
        end else if (ln_clk && !seen_fall) begin
            setup_cnt <= setup_cnt + 1'b1;
        end else if (!ln_clk) begin
            seen_fall <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ln_clk) low_run <= '0;
        else               low_run <= low_run + 1'b1;
    end

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ln_clk && ln_mode && !ln_data)); // R1

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !$past(req_ready)) |-> $stable(ln_mode)); // R3

    AST_SETUP_MIN: assert property (@(posedge clk) disable iff (rst)
        ($fell(ln_clk) && !seen_fall) |-> (setup_cnt >= 16'(SETUP_CYC))); // R4

    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && ln_clk && $past(ln_clk)) |-> $stable(ln_data)); // R5

    AST_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
        $rose(ln_clk) |-> (low_run == 16'(HALF_CYC))); // R5

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && ln_clk && ln_mode && !ln_data)); // R8
endmodule

bind ctl3w_serializer ctl3w_checker #(
    .SETUP_CYC (SETUP_CYC),
    .HALF_CYC  (HALF_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .ln_mode   (ln_mode),
    .ln_clk    (ln_clk),
    .ln_data   (ln_data)
);

// File: tb/ctl3w_serializer_test.sv
module ctl3w_serializer_test;
    localparam int HALF  = 4;
    localparam int SETUP = 19; // ceil(190 ns / 10 ns)

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_phase = 1'b0;
    logic [7:0] req_byte  = 8'h00;
    logic       req_ready, done, ln_mode, ln_clk, ln_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] expq[$];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ctl3w_serializer #(.CLK_PERIOD_PS(10000), .SETUP_NS(190), .HALF_CYC(HALF)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_phase(req_phase), .req_byte(req_byte), .done(done),
        .ln_mode(ln_mode), .ln_clk(ln_clk), .ln_data(ln_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: present a request, wait for acceptance, push the expected item.
    task automatic send(input logic ph, input logic [7:0] b, input bit scribble);
        @(negedge clk);
        req_valid = 1'b1;
        req_phase = ph;
        req_byte  = b;
        while (!req_ready) @(negedge clk);
        expq.push_back({ph, b});
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R6 ready low after accept", req_ready, 0);
        if (scribble) begin
            req_phase = ~ph;
            req_byte  = ~b;
        end
    endtask

    // Monitor: rebuild bytes and measure intervals at falling system edges.
    initial begin : monitor
        logic       prev_clk, prev_done, prev_ready, seen_fall;
        logic [7:0] sh;
        int         bits, lowc, highc, setc;
        prev_clk = 1'b1; prev_done = 1'b0; prev_ready = 1'b1; seen_fall = 1'b0;
        sh = '0; bits = 0; lowc = 0; highc = 0; setc = 0;
        forever begin
            @(negedge clk);
            if (rst) continue;
            if (!req_ready) begin
                if (prev_ready) begin
                    check(expq.size() > 0 && ln_mode == expq[0][8] && ln_clk && !ln_data,
                          "R3 setup levels", {ln_mode, ln_clk, ln_data},
                          {(expq.size() > 0) ? expq[0][8] : 1'b0, 2'b10});
                end
                if (ln_clk && !seen_fall) setc++;
                if (!ln_clk && prev_clk) begin
                    if (!seen_fall)
                        check(setc >= SETUP, "R4 setup cycles", setc, SETUP);
                    else
                        check(highc == HALF, "R5 high half", highc, HALF);
                    seen_fall = 1'b1;
                    lowc = 0;
                end
                if (ln_clk && !prev_clk) begin
                    check(lowc == HALF, "R5 low half", lowc, HALF);
                    sh = {ln_data, sh[7:1]};
                    bits++;
                    if (expq.size() > 0)
                        check(ln_mode == expq[0][8], "R3 mode at latch", ln_mode, expq[0][8]);
                    highc = 0;
                end
                if (!ln_clk) lowc++;
                else if (seen_fall) highc++;
            end
            if (done) begin
                check(req_ready && ln_clk && ln_mode && !ln_data, "R8 idle at done",
                      {req_ready, ln_clk, ln_mode, ln_data}, 4'b1110);
                check(highc == HALF, "R5 last high half", highc, HALF);
                check(bits == 8, "R2 bit count", bits, 8);
                if (expq.size() > 0) begin
                    check(sh == expq[0][7:0], "R2/R7 byte LSB-first", sh, expq[0][7:0]);
                    void'(expq.pop_front());
                end else begin
                    check(1'b0, "R6 unexpected transfer", sh, 0);
                end
                bits = 0; setc = 0; seen_fall = 1'b0; lowc = 0; highc = 0;
            end
            if (prev_done)
                check(!done, "R8 done one cycle", done, 0);
            if (req_ready && !done)
                check(ln_clk && ln_mode && !ln_data, "R1 idle levels",
                      {ln_clk, ln_mode, ln_data}, 3'b110);
            prev_clk = ln_clk; prev_done = done; prev_ready = req_ready;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(req_ready && ln_clk && ln_mode && !ln_data && !done, "R1 reset state",
              {req_ready, ln_clk, ln_mode, ln_data, done}, 5'b11100);
        rst = 1'b0;
        send(1'b0, 8'h01, 1'b0);    // address, single low bit
        send(1'b1, 8'h80, 1'b0);    // data, MSB only, back-to-back (R6)
        send(1'b1, 8'hA5, 1'b1);    // R7: inputs scribbled during transfer
        send(1'b0, 8'h3C, 1'b1);    // R7 with address phase
        send(1'b1, 8'hFF, 1'b0);
        send(1'b0, 8'h00, 1'b0);
        while (expq.size() > 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(req_ready && ln_clk && ln_mode && !ln_data, "R1 idle after traffic",
              {req_ready, ln_clk, ln_mode, ln_data}, 4'b1110);
        finished = 1'b1;
    end

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) check(1'b0, "watchdog expired", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule